// File: doc/BRIEF.md
# Descriptor-Chained DMA Transfer Engine

This block carries out the work of a single DMA channel. When started, it reads a four-word descriptor from memory and then copies data from a source region to a target region. The copy runs in bursts: each burst first reads its elements into a local byte buffer and then writes them out. Elements are 1, 2 or 4 bytes wide. The block updates the addresses and the remaining length as it goes. When a descriptor runs out, it follows the link word to the next descriptor, or it stops if a stop condition holds.

A descriptor can also name a peripheral as the pacer of the transfer. In that case the engine waits for the request level before each burst, and it treats a request that has dropped at the end of a burst as the end of a receive. That event can stop the channel, make it jump to the next descriptor, or just hold it until the request returns. If the compare status input is set and the link word carries its branch bit, the next descriptor is taken from 32 bytes further on. There is also a direct mode, which skips fetching and takes its source, target and command words from the configuration inputs.

The memory port is a simple one. It has byte addressing on word boundaries and byte enables, and read data returns one cycle after the read strobe. Events appear as single-cycle strobes.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset `busy` is 0, no event strobe is high, and neither `mem_rd` nor `mem_wr` is asserted while `busy` is 0.
- R2: A fetch reads four words in this order: link, source, target, command. They are read from the link value with bits [3:0] cleared, plus 32 when link bit 1 and `cmp_status` are both 1. When command bit 22 is set, `ev_start` pulses once the fetch completes.
- R3: Command bits [15:14] set the element width: code 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes, and 0 also gives 1 byte. Bit 31 steps the source and bit 30 steps the target by the width. Byte lane i of a word holds address offset i (`mem_be` bit i, `mem_wdata[8i+7:8i]`).
- R4: A burst covers the smaller of (4 << command bits [17:16]) bytes and the remaining length. Every element of a burst is read before any element is written, so overlapping regions copy the original data.
- R5: After each burst, command bits [12:0] (`cur_cmd`) hold the remaining byte length.
- R6: When command bit 29 is set, the fetched source has bits [1:0] cleared. When command bit 28 is set, the fetched target has bits [1:0] cleared. When either bit is set, no burst starts while `dreq` is 0.
- R7: In paced mode, if `dreq` is 0 in the cycle after a burst's last write, `ev_eor` pulses. The channel then stops if `eor_stop_en` is set. If not, it fetches the next descriptor when `eor_jump_en` is set and direct mode is off. Otherwise it waits for the request.
- R8: When the length reaches 0, `ev_end` pulses if command bit 21 is set. The channel stops (`ev_stop` pulses and `busy` falls) if direct mode is on, link bit 0 is set, or `eor_stop_en` is set. Otherwise it fetches the descriptor the link points to.
- R9: In direct mode, `start` loads `cfg_src`, `cfg_dst`, `cfg_cmd` and `cfg_next` and moves data with no descriptor reads.
- R10: A `start` pulse while `busy` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| direct_mode | input | 1 | 1: use cfg words directly, no descriptor fetch |
| cfg_next | input | 32 | First link word |
| cfg_src | input | 32 | Source address for direct mode |
| cfg_dst | input | 32 | Target address for direct mode |
| cfg_cmd | input | 32 | Command word for direct mode |
| cmp_status | input | 1 | Compare status; enables the +32 branch |
| eor_stop_en | input | 1 | Stop on end of receive or on length exhaustion |
| eor_jump_en | input | 1 | Fetch next descriptor on end of receive |
| dreq | input | 1 | Peripheral request level for paced transfers |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data, lane-placed |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Channel running |
| cur_next | output | 32 | Current link word |
| cur_src | output | 32 | Current source address |
| cur_dst | output | 32 | Current target address |
| cur_cmd | output | 32 | Current command word with remaining length |
| ev_start | output | 1 | Descriptor-start event strobe |
| ev_end | output | 1 | Length-exhausted event strobe |
| ev_eor | output | 1 | End-of-receive event strobe |
| ev_stop | output | 1 | Channel-stopped event strobe |

## Verification
The hardest case to reach is an end of receive in the middle of a descriptor, because the request must fall in exactly the cycle after a burst's final write. The stimulus watches `mem_wr` and drops `dreq` on the falling clock edge while the first burst's last write is on the bus. This places the request change in the decision cycle. The case is run once with stop-on-receive-end, where the remaining length must stay at the partial value, and once with jump, where a second descriptor must take over and the first one's tail must stay unwritten. Overlapping source and target regions show at the ports whether a burst is really buffered.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    parameter int WORD_W    = 32;
    parameter int LEN_W     = 13;
    parameter int BUF_BYTES = 32;
    localparam int IDX_W    = $clog2(BUF_BYTES);
    localparam int BOFF_W   = IDX_W + 2;

    localparam int C_INC_SRC  = 31;
    localparam int C_INC_DST  = 30;
    localparam int C_PACE_SRC = 29;
    localparam int C_PACE_DST = 28;
    localparam int C_START_IE = 22;
    localparam int C_END_IE   = 21;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_A, ST_FETCH_D, ST_CHECK,
        ST_RD_A, ST_RD_D, ST_WR, ST_DECIDE
    } eng_st_e;

    typedef struct packed {
        eng_st_e                       st;
        logic                          direct;
        logic [WORD_W-1:0]             link;
        logic [WORD_W-1:0]             src;
        logic [WORD_W-1:0]             dst;
        logic [WORD_W-1:0]             cmd;
        logic [WORD_W-1:0]             faddr;
        logic [1:0]                    widx;
        logic [BOFF_W-1:0]             boff;
        logic [BOFF_W-1:0]             bbytes;
        logic                          burst;
        logic [BUF_BYTES-1:0][7:0]     bbuf;
        logic                          ev_s;
        logic                          ev_e;
        logic                          ev_r;
        logic                          ev_p;
    } eng_ctx_t;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_chain_pkg::*;
(
    input  logic [WORD_W-1:0] cmd,
    output logic [2:0]        ebytes,
    output logic [BOFF_W-1:0] burst_cap,
    output logic              paced,
    output logic              inc_s,
    output logic              inc_d,
    output logic [LEN_W-1:0]  len
);
    always_comb begin
        unique case (cmd[15:14])
            2'd2:    ebytes = 3'd2;
            2'd3:    ebytes = 3'd4;
            default: ebytes = 3'd1;
        endcase
        burst_cap = BOFF_W'(4) << cmd[17:16];
        paced     = cmd[C_PACE_SRC] | cmd[C_PACE_DST];
        inc_s     = cmd[C_INC_SRC];
        inc_d     = cmd[C_INC_DST];
        len       = cmd[LEN_W-1:0];
    end
endmodule

// File: rtl/dma_lane_unit.sv
module dma_lane_unit
    import dma_chain_pkg::*;
(
    input  logic [2:0]        ebytes,
    input  logic [1:0]        rd_lo,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] elem_rd,
    input  logic [1:0]        wr_lo,
    input  logic [WORD_W-1:0] elem_wr,
    output logic [WORD_W-1:0] wdata,
    output logic [3:0]        be
);
    logic [3:0]        lane_m;
    logic [WORD_W-1:0] bit_m;

    always_comb begin
        unique case (ebytes)
            3'd4:    lane_m = 4'hF;
            3'd2:    lane_m = 4'h3;
            default: lane_m = 4'h1;
        endcase
        for (int k = 0; k < 4; k++) begin
            bit_m[8*k +: 8] = {8{lane_m[k]}};
        end
        elem_rd = (rdata >> {rd_lo, 3'b000}) & bit_m;
        wdata   = (elem_wr & bit_m) << {wr_lo, 3'b000};
        be      = lane_m << wr_lo;
    end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              direct_mode,
    input  logic [31:0]       cfg_next,
    input  logic [31:0]       cfg_src,
    input  logic [31:0]       cfg_dst,
    input  logic [31:0]       cfg_cmd,
    input  logic              cmp_status,
    input  logic              eor_stop_en,
    input  logic              eor_jump_en,
    input  logic              dreq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic [31:0]       cur_next,
    output logic [31:0]       cur_src,
    output logic [31:0]       cur_dst,
    output logic [31:0]       cur_cmd,
    output logic              ev_start,
    output logic              ev_end,
    output logic              ev_eor,
    output logic              ev_stop
);
    eng_ctx_t q, d;

    logic [2:0]        ebytes;
    logic [BOFF_W-1:0] burst_cap;
    logic              paced, inc_s, inc_d;
    logic [LEN_W-1:0]  len;
    logic [WORD_W-1:0] elem_rd, elem_wr;

    dma_cmd_decode dec_i (
        .cmd(q.cmd), .ebytes(ebytes), .burst_cap(burst_cap),
        .paced(paced), .inc_s(inc_s), .inc_d(inc_d), .len(len)
    );

    dma_lane_unit lane_i (
        .ebytes(ebytes), .rd_lo(q.src[1:0]), .rdata(mem_rdata), .elem_rd(elem_rd),
        .wr_lo(q.dst[1:0]), .elem_wr(elem_wr), .wdata(mem_wdata), .be(mem_be)
    );

    function automatic logic [31:0] desc_base(logic [31:0] lk, logic cmp);
        desc_base = {lk[31:4], 4'b0000} + ((lk[1] && cmp) ? 32'd32 : 32'd0);
    endfunction

    // gather one element from the burst buffer for the write phase
    always_comb begin
        logic [BOFF_W-1:0] ix;
        elem_wr = '0;
        for (int k = 0; k < 4; k++) begin
            ix = q.boff + BOFF_W'(k);
            if (3'(k) < ebytes && ix < BOFF_W'(BUF_BYTES)) begin
                elem_wr[8*k +: 8] = q.bbuf[ix[IDX_W-1:0]];
            end
        end
    end

    // memory port, driven from the registered state
    always_comb begin
        mem_rd   = (q.st == ST_FETCH_A) || (q.st == ST_RD_A);
        mem_wr   = (q.st == ST_WR);
        unique case (q.st)
            ST_FETCH_A: mem_addr = q.faddr + {28'd0, q.widx, 2'b00};
            ST_RD_A:    mem_addr = {q.src[31:2], 2'b00};
            ST_WR:      mem_addr = {q.dst[31:2], 2'b00};
            default:    mem_addr = '0;
        endcase
    end

    always_comb begin
        logic [BOFF_W-1:0] ix;
        logic [BOFF_W-1:0] step;
        logic              eor, fin, halt;
        d      = q;
        d.ev_s = 1'b0;
        d.ev_e = 1'b0;
        d.ev_r = 1'b0;
        d.ev_p = 1'b0;
        step   = BOFF_W'(ebytes);
        eor    = 1'b0;
        fin    = 1'b0;
        halt   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.direct = direct_mode;
                    d.link   = cfg_next;
                    d.burst  = 1'b0;
                    if (direct_mode) begin
                        d.src = cfg_src;
                        d.dst = cfg_dst;
                        d.cmd = cfg_cmd;
                        d.st  = ST_CHECK;
                    end else begin
                        d.faddr = desc_base(cfg_next, cmp_status);
                        d.widx  = 2'd0;
                        d.st    = ST_FETCH_A;
                    end
                end
            end
            ST_FETCH_A: d.st = ST_FETCH_D;
            ST_FETCH_D: begin
                unique case (q.widx)
                    2'd0: d.link = mem_rdata;
                    2'd1: d.src  = mem_rdata;
                    2'd2: d.dst  = mem_rdata;
                    default: begin
                        d.cmd = mem_rdata;
                        if (mem_rdata[C_PACE_SRC]) d.src[1:0] = 2'b00;
                        if (mem_rdata[C_PACE_DST]) d.dst[1:0] = 2'b00;
                        d.ev_s = mem_rdata[C_START_IE];
                    end
                endcase
                d.widx = q.widx + 2'd1;
                d.st   = (q.widx == 2'd3) ? ST_CHECK : ST_FETCH_A;
                d.burst = 1'b0;
            end
            ST_CHECK: begin
                if (len == '0) begin
                    d.burst = 1'b0;
                    d.st    = ST_DECIDE;
                end else if (!paced || dreq) begin
                    d.bbytes = ({{(LEN_W-BOFF_W){1'b0}}, burst_cap} < len)
                               ? burst_cap : BOFF_W'(len);
                    d.boff   = '0;
                    d.st     = ST_RD_A;
                end
            end
            ST_RD_A: d.st = ST_RD_D;
            ST_RD_D: begin
                for (int k = 0; k < 4; k++) begin
                    ix = q.boff + BOFF_W'(k);
                    if (3'(k) < ebytes && ix < BOFF_W'(BUF_BYTES)) begin
                        d.bbuf[ix[IDX_W-1:0]] = elem_rd[8*k +: 8];
                    end
                end
                if (inc_s) d.src = q.src + {29'd0, ebytes};
                if (q.boff + step >= q.bbytes) begin
                    d.boff = '0;
                    d.st   = ST_WR;
                end else begin
                    d.boff = q.boff + step;
                    d.st   = ST_RD_A;
                end
            end
            ST_WR: begin
                if (inc_d) d.dst = q.dst + {29'd0, ebytes};
                if (q.boff + step >= q.bbytes) begin
                    d.cmd[LEN_W-1:0] = len - LEN_W'(q.bbytes);
                    d.burst = 1'b1;
                    d.st    = ST_DECIDE;
                end else begin
                    d.boff = q.boff + step;
                end
            end
            default: begin
                eor  = q.burst && paced && !dreq;
                fin  = (len == '0);
                halt = (eor && eor_stop_en) ||
                       (fin && (q.direct || q.link[0] || eor_stop_en));
                d.ev_r  = eor;
                d.ev_e  = fin && q.cmd[C_END_IE];
                d.burst = 1'b0;
                if (halt) begin
                    d.ev_p = 1'b1;
                    d.st   = ST_IDLE;
                end else if (fin || (eor && eor_jump_en && !q.direct)) begin
                    d.faddr = desc_base(q.link, cmp_status);
                    d.widx  = 2'd0;
                    d.st    = ST_FETCH_A;
                end else begin
                    d.st = ST_CHECK;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign cur_next = q.link;
    assign cur_src  = q.src;
    assign cur_dst  = q.dst;
    assign cur_cmd  = q.cmd;
    assign ev_start = q.ev_s;
    assign ev_end   = q.ev_e;
    assign ev_eor   = q.ev_r;
    assign ev_stop  = q.ev_p;
endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic [3:0] mem_be,
    input logic       dreq,
    input logic       ev_start,
    input logic       ev_eor,
    input logic       ev_stop
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd || mem_wr));

    assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |-> busy);

    assert_write_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_be != 4'h0));

    assert_single_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    assert_eor_after_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_eor |-> !$past(dreq));

    assert_stop_is_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |-> !busy);
endmodule

bind dma_chain_engine dma_chain_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_be(mem_be), .dreq(dreq), .ev_start(ev_start), .ev_eor(ev_eor),
    .ev_stop(ev_stop)
);

// File: tb/dma_chain_engine_tb_top.sv
module dma_chain_engine_tb_top;
    localparam logic [31:0] CINC_S  = 32'h8000_0000;
    localparam logic [31:0] CINC_D  = 32'h4000_0000;
    localparam logic [31:0] CPACE_S = 32'h2000_0000;
    localparam logic [31:0] CSTART  = 32'h0040_0000;
    localparam logic [31:0] CEND    = 32'h0020_0000;
    localparam logic [31:0] W0      = 32'h0000_0000;
    localparam logic [31:0] W1      = 32'h0000_4000;
    localparam logic [31:0] W2      = 32'h0000_8000;
    localparam logic [31:0] W4      = 32'h0000_C000;
    localparam logic [31:0] SZ8     = 32'h0001_0000;

    logic clk = 0, rst_n = 0;
    logic start = 0, direct_mode = 0, cmp_status = 0, eor_stop_en = 0, eor_jump_en = 0, dreq = 0;
    logic [31:0] cfg_next = 0, cfg_src = 0, cfg_dst = 0, cfg_cmd = 0;
    logic mem_rd, mem_wr, busy, ev_start, ev_end, ev_eor, ev_stop;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, cur_next, cur_src, cur_dst, cur_cmd;
    logic [3:0] mem_be;
    logic [31:0] mem [0:255];
    int n_chk = 0, n_bad = 0;
    int c_s = 0, c_e = 0, c_r = 0, c_p = 0, c_rd = 0, c_wr = 0;
    int b_s, b_e, b_r, b_p, b_rd, b_wr;

    always #2.5 clk = ~clk;

    dma_chain_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .direct_mode(direct_mode),
        .cfg_next(cfg_next), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cmd(cfg_cmd),
        .cmp_status(cmp_status), .eor_stop_en(eor_stop_en), .eor_jump_en(eor_jump_en),
        .dreq(dreq), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .busy(busy),
        .cur_next(cur_next), .cur_src(cur_src), .cur_dst(cur_dst), .cur_cmd(cur_cmd),
        .ev_start(ev_start), .ev_end(ev_end), .ev_eor(ev_eor), .ev_stop(ev_stop)
    );

    always @(posedge clk) begin
        if (mem_wr) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (rst_n) begin
            if (ev_start) c_s++;
            if (ev_end)   c_e++;
            if (ev_eor)   c_r++;
            if (ev_stop)  c_p++;
            if (mem_rd)   c_rd++;
            if (mem_wr)   c_wr++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic snap();
        b_s = c_s; b_e = c_e; b_r = c_r; b_p = c_p; b_rd = c_rd; b_wr = c_wr;
    endtask

    task automatic put_desc(input int a, input logic [31:0] lk, s, t, c);
        mem[a/4] = lk; mem[a/4+1] = s; mem[a/4+2] = t; mem[a/4+3] = c;
    endtask

    task automatic go(input logic [31:0] lk, input logic dm);
        @(negedge clk);
        cfg_next = lk; direct_mode = dm; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle(input string tag);
        int t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        @(negedge clk);
        if (t >= 5000) chk({tag, " timeout"}, 32'd1, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", {31'd0, busy}, 32'd0);
        chk("R1 events after reset", {28'd0, ev_start, ev_end, ev_eor, ev_stop}, 32'd0);
        chk("R1 no access while idle", c_rd + c_wr, 32'd0);
    endtask

    task automatic t_basic();
        for (int i = 0; i < 4; i++) mem[32'h200/4 + i] = 32'hA000_0000 + i;
        put_desc(32'h100, 32'h001, 32'h200, 32'h300, CINC_S | CINC_D | CSTART | CEND | SZ8 | W4 | 16);
        snap(); go(32'h100, 0); wait_idle("basic");
        for (int i = 0; i < 4; i++) chk("R3 word copy", mem[32'h300/4 + i], 32'hA000_0000 + i);
        chk("R2 start event", c_s - b_s, 1);
        chk("R8 end event", c_e - b_e, 1);
        chk("R8 stop event", c_p - b_p, 1);
        chk("R5 length written back", {19'd0, cur_cmd[12:0]}, 0);
        chk("R3 source stepped", cur_src, 32'h210);
        chk("R3 target stepped", cur_dst, 32'h310);
    endtask

    task automatic t_overlap();
        mem[32'h400/4] = 32'h1111_1111; mem[32'h404/4] = 32'h2222_2222; mem[32'h408/4] = 32'h3333_3333;
        put_desc(32'h110, 32'h001, 32'h400, 32'h404, CINC_S | CINC_D | SZ8 | W4 | 8);
        go(32'h110, 0); wait_idle("overlap");
        chk("R4 buffered first word", mem[32'h404/4], 32'h1111_1111);
        chk("R4 buffered second word", mem[32'h408/4], 32'h2222_2222);
    endtask

    task automatic t_chain();
        mem[32'h210/4] = 32'hC0DE_0001; mem[32'h214/4] = 32'hC0DE_0002;
        put_desc(32'h140, 32'h180, 32'h210, 32'h320, CINC_S | CINC_D | CSTART | W4 | 4);
        put_desc(32'h180, 32'h001, 32'h214, 32'h324, CINC_S | CINC_D | CSTART | W4 | 4);
        snap(); go(32'h140, 0); wait_idle("chain");
        chk("R8 first link copy", mem[32'h320/4], 32'hC0DE_0001);
        chk("R8 second link copy", mem[32'h324/4], 32'hC0DE_0002);
        chk("R2 start per descriptor", c_s - b_s, 2);
        chk("R8 end gated by bit 21", c_e - b_e, 0);
        chk("R8 single stop", c_p - b_p, 1);
    endtask

    task automatic t_branch();
        mem[32'h218/4] = 32'h5555_0000; mem[32'h21C/4] = 32'h7777_0000;
        mem[32'h330/4] = 0; mem[32'h334/4] = 0;
        put_desc(32'h1C0, 32'h001, 32'h218, 32'h330, CINC_S | CINC_D | W4 | 4);
        put_desc(32'h1E0, 32'h001, 32'h21C, 32'h334, CINC_S | CINC_D | W4 | 4);
        cmp_status = 1;
        go(32'h1C2, 0); wait_idle("branch");
        cmp_status = 0;
        chk("R2 branch target used", mem[32'h334/4], 32'h7777_0000);
        chk("R2 plain target skipped", mem[32'h330/4], 32'h0);
    endtask

    task automatic t_lanes();
        mem[32'h220/4] = 32'h4433_2211; mem[32'h340/4] = 0;
        put_desc(32'h120, 32'h001, 32'h220, 32'h341, CINC_S | W1 | 3);
        go(32'h120, 0); wait_idle("byte");
        chk("R3 byte lane fixed target", mem[32'h340/4], 32'h0000_3300);
        chk("R3 byte source step", cur_src, 32'h223);
        chk("R3 fixed target", cur_dst, 32'h341);
        put_desc(32'h120, 32'h001, 32'h220, 32'h342, CINC_S | W0 | 3);
        go(32'h120, 0); wait_idle("code0");
        chk("R3 width code 0 as byte", mem[32'h340/4], 32'h0033_3300);
        mem[32'h224/4] = 32'hDDCC_BBAA; mem[32'h348/4] = 0; mem[32'h34C/4] = 0;
        put_desc(32'h120, 32'h001, 32'h224, 32'h34A, CINC_S | CINC_D | W2 | 4);
        go(32'h120, 0); wait_idle("half");
        chk("R3 halfword upper lanes", mem[32'h348/4], 32'hBBAA_0000);
        chk("R3 halfword next word", mem[32'h34C/4], 32'h0000_DDCC);
    endtask

    task automatic t_direct();
        mem[32'h228/4] = 32'h600D_F00D;
        cfg_src = 32'h228; cfg_dst = 32'h350; cfg_cmd = CINC_S | CINC_D | CEND | W4 | 4;
        snap(); go(32'h100, 1); wait_idle("direct");
        chk("R9 direct copy", mem[32'h350/4], 32'h600D_F00D);
        chk("R9 no descriptor reads", c_rd - b_rd, 1);
        chk("R9 no start event", c_s - b_s, 0);
        chk("R8 direct stops", c_p - b_p, 1);
    endtask

    task automatic t_paced_wait();
        mem[32'h22C/4] = 32'h0BAD_0002;
        put_desc(32'h130, 32'h001, 32'h22B, 32'h354, CPACE_S | CINC_S | CINC_D | W4 | 8);
        dreq = 0; snap(); go(32'h130, 0);
        repeat (40) @(negedge clk);
        chk("R6 held without request", c_wr - b_wr, 0);
        chk("R6 still busy", {31'd0, busy}, 1);
        chk("R6 source low bits cleared", cur_src, 32'h228);
        dreq = 1; wait_idle("paced"); dreq = 0;
        chk("R6 paced word 0", mem[32'h354/4], 32'h600D_F00D);
        chk("R6 paced word 1", mem[32'h358/4], 32'h0BAD_0002);
        chk("R7 no eor with request", c_r - b_r, 0);
    endtask

    task automatic t_eor_stop();
        mem[32'h360/4] = 0; mem[32'h364/4] = 0;
        put_desc(32'h150, 32'h001, 32'h228, 32'h360, CPACE_S | CINC_S | CINC_D | W4 | 12);
        eor_stop_en = 1; dreq = 1; snap(); go(32'h150, 0);
        while (!mem_wr) @(negedge clk);
        dreq = 0;
        wait_idle("eor stop"); eor_stop_en = 0;
        chk("R7 eor event", c_r - b_r, 1);
        chk("R7 stop on eor", c_p - b_p, 1);
        chk("R5 partial length", {19'd0, cur_cmd[12:0]}, 8);
        chk("R7 first word moved", mem[32'h360/4], 32'h600D_F00D);
        chk("R7 second word untouched", mem[32'h364/4], 0);
    endtask

    task automatic t_eor_jump();
        mem[32'h368/4] = 0; mem[32'h36C/4] = 0; mem[32'h230/4] = 32'hFEED_0003; mem[32'h378/4] = 0;
        put_desc(32'h160, 32'h1A0, 32'h228, 32'h368, CPACE_S | CINC_S | CINC_D | CSTART | W4 | 12);
        put_desc(32'h1A0, 32'h001, 32'h230, 32'h378, CINC_S | CINC_D | CSTART | W4 | 4);
        eor_jump_en = 1; dreq = 1; snap(); go(32'h160, 0);
        while (!mem_wr) @(negedge clk);
        dreq = 0;
        wait_idle("eor jump"); eor_jump_en = 0;
        chk("R7 eor before jump", c_r - b_r, 1);
        chk("R7 jump fetched next", c_s - b_s, 2);
        chk("R7 jumped copy", mem[32'h378/4], 32'hFEED_0003);
        chk("R7 abandoned tail", mem[32'h36C/4], 0);
    endtask

    task automatic t_restart_ignored();
        mem[32'h370/4] = 0;
        put_desc(32'h170, 32'h001, 32'h228, 32'h370, CPACE_S | CINC_S | CINC_D | CSTART | W4 | 4);
        dreq = 0; snap(); go(32'h170, 0);
        repeat (20) @(negedge clk);
        go(32'h1A0, 0);
        repeat (20) @(negedge clk);
        chk("R10 link unchanged", cur_next, 32'h001);
        chk("R10 no second fetch", c_rd - b_rd, 4);
        dreq = 1; wait_idle("restart"); dreq = 0;
        chk("R10 original copy", mem[32'h370/4], 32'h600D_F00D);
        chk("R10 one start event", c_s - b_s, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 0;
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_overlap();
        t_chain();
        t_branch();
        t_lanes();
        t_direct();
        t_paced_wait();
        t_eor_stop();
        t_eor_jump();
        t_restart_ignored();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule